// File: doc/BRIEF.md
# Floating Multiply/Divide Unit

This block multiplies or divides two numbers held in a compact floating format: a sign bit, an 8-bit two's-complement exponent and a 16-bit mantissa. The mantissa carries its leading one explicitly, so its most significant bit is set, and the binary point sits just below that bit, which leaves 15 fraction bits. Results come back in the same format. The format uses sign-magnitude, so the mantissa is never complemented. It suits a calculator-style or embedded datapath that needs products and quotients of moderate precision without the cost of a full IEEE-754 unit.

A one-cycle `start` strobe captures both operands and the operation select. While the unit works, `busy` stays high. A one-cycle `done` pulse then marks a new result and its flags, and these hold until the next `done`. A multiply takes one 16x16 unsigned product followed by a one-step post-normalize. A divide runs a restoring shift-subtract loop that produces one quotient bit per clock and then normalizes by at most one place. Results that leave the exponent range saturate and raise a flag. A zero divisor is reported on its own flag.

Top module: `fpmd_unit`

## Requirements
- R1: An operand counts as zero when its mantissa bit 15 is 0, whatever its other bits. A zero result is always sign 0, exponent 0, mantissa 0.
- R2: Multiply forms P = ma*mb (32 bits). If P[31]=1 the result mantissa is P[31:16] and the exponent is ea+eb+1. Otherwise the mantissa is P[30:15] and the exponent is ea+eb. Discarded bits are truncated.
- R3: Every nonzero result, including a saturated one, carries sign a_sign XOR b_sign.
- R4: A multiply with either operand zero returns zero with no flag set.
- R5: Divide forms Q = floor(ma*2^16/mb) (17 bits). If Q[16]=1 the mantissa is Q[16:1] and the exponent is ea-eb. Otherwise the mantissa is Q[15:0] and the exponent is ea-eb-1.
- R6: A result exponent above +127 sets `ovf` and returns mantissa 0xFFFF with exponent 0x7F.
- R7: A result exponent below -128 sets `unf` and returns zero.
- R8: A divide by a zero divisor sets `dvz` and returns mantissa 0xFFFF with exponent 0x7F. This holds even when the dividend is also zero. At most one of `ovf`, `unf` and `dvz` is set.
- R9: A divide of a zero dividend by a nonzero divisor returns zero with no flag set.
- R10: `busy` rises on the clock edge that accepts `start` and falls on the edge that raises `done`. `done` is high for exactly one cycle. It rises 2 clock edges after the accepting edge for a multiply and 18 for a divide.
- R11: A `start` while `busy` is high is ignored. The running operation finishes with its original operands and timing.
- R12: After reset, `busy`, `done`, the flags and the result are all 0. The result and flags change only on the edge that raises `done` and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request, accepted only when idle |
| op_div | input | 1 | 1 = divide a by b, 0 = multiply |
| a_sign | input | 1 | Sign of operand a (dividend) |
| a_exp | input | 8 | Two's-complement exponent of a |
| a_man | input | 16 | Normalized mantissa of a |
| b_sign | input | 1 | Sign of operand b (divisor) |
| b_exp | input | 8 | Two's-complement exponent of b |
| b_man | input | 16 | Normalized mantissa of b |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: new result valid |
| r_sign | output | 1 | Result sign |
| r_exp | output | 8 | Result exponent |
| r_man | output | 16 | Result mantissa |
| ovf | output | 1 | Exponent overflow, result saturated |
| unf | output | 1 | Exponent underflow, result zeroed |
| dvz | output | 1 | Divide by zero |

## Verification
A wrong quotient bit, remainder or step count in the divider appears at the ports 18 cycles after `start`. It shows either as a mantissa off in its low bits or as a `done` pulse that arrives early or late. The pulse timing is therefore checked on every operation, both against a cycle counter and in the bench. A wrong normalize choice or exponent adjust shows on the same `done` pulse: the result is out by a factor of two, or its mantissa MSB is clear. The vectors sit at exponent limits (+127, -128 and one past each) and at each zero-operand combination. A mis-ordered priority among the saturate, zero and divide-by-zero cases therefore shows as a wrong flag or a wrong canonical zero.

// File: rtl/fpmd_pkg.sv
package fpmd_pkg;

    localparam int MAN_W = 16;
    localparam int EXP_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV,
        ST_FIN
    } fpmd_state_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic dvz;
    } fpmd_flags_t;

    // A mantissa with a clear leading bit stands for zero.
    function automatic logic man_is_zero(input logic lead_bit);
        return !lead_bit;
    endfunction

endpackage

// File: rtl/fpmd_mul_core.sv
module fpmd_mul_core #(
    parameter int MAN_W = fpmd_pkg::MAN_W
) (
    input  logic [MAN_W-1:0] man_a,
    input  logic [MAN_W-1:0] man_b,
    output logic [MAN_W-1:0] man_n,
    output logic             exp_inc
);
    localparam int PW = 2 * MAN_W;

    logic [PW-1:0] prod;

    assign prod    = {{MAN_W{1'b0}}, man_a} * {{MAN_W{1'b0}}, man_b};
    assign exp_inc = prod[PW-1];
    // Product lies in [1,4): one shift at most brings it back to [1,2).
    assign man_n   = exp_inc ? MAN_W'(prod >> MAN_W) : MAN_W'(prod >> (MAN_W - 1));

endmodule

// File: rtl/fpmd_div_core.sv
module fpmd_div_core #(
    parameter int MAN_W = fpmd_pkg::MAN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [MAN_W-1:0] dividend,
    input  logic [MAN_W-1:0] divisor,
    output logic [MAN_W:0]   quo,
    output logic             last
);
    localparam int QW = MAN_W + 1;
    localparam int CW = $clog2(QW + 1);

    logic [MAN_W:0]   rem;
    logic [MAN_W-1:0] dsr;
    logic [CW-1:0]    cnt;
    logic             fits;

    assign fits = (rem >= {1'b0, dsr});
    assign last = step && (cnt == CW'(QW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            dsr <= '0;
            quo <= '0;
            cnt <= '0;
        end else if (load) begin
            rem <= {1'b0, dividend};
            dsr <= divisor;
            quo <= '0;
            cnt <= '0;
        end else if (step) begin
            if (fits) begin
                rem <= (rem - {1'b0, dsr}) << 1;
                quo <= {quo[QW-2:0], 1'b1};
            end else begin
                rem <= rem << 1;
                quo <= {quo[QW-2:0], 1'b0};
            end
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/fpmd_pack.sv
module fpmd_pack
    import fpmd_pkg::*;
#(
    parameter int MAN_W = fpmd_pkg::MAN_W,
    parameter int EXP_W = fpmd_pkg::EXP_W
) (
    input  logic             is_div,
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic             zero_a,
    input  logic             zero_b,
    input  logic [MAN_W-1:0] mul_man,
    input  logic             mul_inc,
    input  logic [MAN_W:0]   quo,
    output logic             out_sign,
    output logic [EXP_W-1:0] out_exp,
    output logic [MAN_W-1:0] out_man,
    output fpmd_flags_t      out_flags
);
    localparam int EW    = EXP_W + 2;
    localparam int MAX_I = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [EW-1:0] E_MAX = EW'(MAX_I);
    localparam logic signed [EW-1:0] E_MIN = ~E_MAX;

    logic signed [EW-1:0] ea_x, eb_x, adj, e_sum;
    logic [MAN_W-1:0]     man_n;
    logic                 sgn, res_zero, div_zero;

    assign ea_x = {{(EW-EXP_W){exp_a[EXP_W-1]}}, exp_a};
    assign eb_x = {{(EW-EXP_W){exp_b[EXP_W-1]}}, exp_b};
    assign sgn  = sign_a ^ sign_b;

    always_comb begin
        if (is_div) begin
            // Quotient lies in (0.5,2): drop the lsb or use the guard bit.
            man_n = quo[MAN_W] ? MAN_W'(quo >> 1) : MAN_W'(quo);
            adj   = quo[MAN_W] ? '0 : '1;
            e_sum = ea_x - eb_x + adj;
        end else begin
            man_n = mul_man;
            adj   = {{(EW-1){1'b0}}, mul_inc};
            e_sum = ea_x + eb_x + adj;
        end
    end

    assign div_zero = is_div && zero_b;
    assign res_zero = is_div ? zero_a : (zero_a || zero_b);

    always_comb begin
        out_sign  = 1'b0;
        out_exp   = '0;
        out_man   = '0;
        out_flags = '0;
        if (div_zero) begin
            out_sign      = sgn;
            out_exp       = EXP_W'(MAX_I);
            out_man       = '1;
            out_flags.dvz = 1'b1;
        end else if (res_zero) begin
            out_man = '0;
        end else if (e_sum > E_MAX) begin
            out_sign      = sgn;
            out_exp       = EXP_W'(MAX_I);
            out_man       = '1;
            out_flags.ovf = 1'b1;
        end else if (e_sum < E_MIN) begin
            out_flags.unf = 1'b1;
        end else begin
            out_sign = sgn;
            out_exp  = e_sum[EXP_W-1:0];
            out_man  = man_n;
        end
    end

endmodule

// File: rtl/fpmd_unit.sv
module fpmd_unit
    import fpmd_pkg::*;
#(
    parameter int MAN_W = fpmd_pkg::MAN_W,
    parameter int EXP_W = fpmd_pkg::EXP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_div,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MAN_W-1:0] a_man,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MAN_W-1:0] b_man,
    output logic             busy,
    output logic             done,
    output logic             r_sign,
    output logic [EXP_W-1:0] r_exp,
    output logic [MAN_W-1:0] r_man,
    output logic             ovf,
    output logic             unf,
    output logic             dvz
);
    fpmd_state_e      st;
    logic             div_q, sa_q, sb_q, za_q, zb_q;
    logic [EXP_W-1:0] ea_q, eb_q;
    logic [MAN_W-1:0] ma_q, mb_q;
    logic [MAN_W-1:0] mul_man, mman_q;
    logic             mul_inc, minc_q;
    logic [MAN_W:0]   quo;
    logic             div_last, accept;
    logic             p_sign;
    logic [EXP_W-1:0] p_exp;
    logic [MAN_W-1:0] p_man;
    fpmd_flags_t      p_flags;

    assign accept = start && (st == ST_IDLE);
    assign busy   = (st != ST_IDLE);

    fpmd_mul_core #(.MAN_W(MAN_W)) u_mul (
        .man_a   (ma_q),
        .man_b   (mb_q),
        .man_n   (mul_man),
        .exp_inc (mul_inc)
    );

    fpmd_div_core #(.MAN_W(MAN_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && op_div),
        .step     (st == ST_DIV),
        .dividend (a_man),
        .divisor  (b_man),
        .quo      (quo),
        .last     (div_last)
    );

    fpmd_pack #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_pack (
        .is_div    (div_q),
        .sign_a    (sa_q),
        .sign_b    (sb_q),
        .exp_a     (ea_q),
        .exp_b     (eb_q),
        .zero_a    (za_q),
        .zero_b    (zb_q),
        .mul_man   (mman_q),
        .mul_inc   (minc_q),
        .quo       (quo),
        .out_sign  (p_sign),
        .out_exp   (p_exp),
        .out_man   (p_man),
        .out_flags (p_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            div_q  <= 1'b0;
            sa_q   <= 1'b0;
            sb_q   <= 1'b0;
            za_q   <= 1'b0;
            zb_q   <= 1'b0;
            ea_q   <= '0;
            eb_q   <= '0;
            ma_q   <= '0;
            mb_q   <= '0;
            mman_q <= '0;
            minc_q <= 1'b0;
            done   <= 1'b0;
            r_sign <= 1'b0;
            r_exp  <= '0;
            r_man  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
            dvz    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        div_q <= op_div;
                        sa_q  <= a_sign;
                        sb_q  <= b_sign;
                        ea_q  <= a_exp;
                        eb_q  <= b_exp;
                        ma_q  <= a_man;
                        mb_q  <= b_man;
                        za_q  <= man_is_zero(a_man[MAN_W-1]);
                        zb_q  <= man_is_zero(b_man[MAN_W-1]);
                        st    <= op_div ? ST_DIV : ST_MUL;
                    end
                end
                ST_MUL: begin
                    mman_q <= mul_man;
                    minc_q <= mul_inc;
                    st     <= ST_FIN;
                end
                ST_DIV: begin
                    if (div_last) st <= ST_FIN;
                end
                default: begin
                    r_sign <= p_sign;
                    r_exp  <= p_exp;
                    r_man  <= p_man;
                    ovf    <= p_flags.ovf;
                    unf    <= p_flags.unf;
                    dvz    <= p_flags.dvz;
                    done   <= 1'b1;
                    st     <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/fpmd_unit_chk.sv
module fpmd_unit_chk #(
    parameter int MAN_W = 16,
    parameter int EXP_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             op_div,
    input logic             busy,
    input logic             done,
    input logic             r_sign,
    input logic [EXP_W-1:0] r_exp,
    input logic [MAN_W-1:0] r_man,
    input logic             ovf,
    input logic             unf,
    input logic             dvz
);
    localparam int MUL_LAT = 2;
    localparam int DIV_LAT = MAN_W + 2;
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'((1 << (EXP_W - 1)) - 1);

    logic [7:0] lat;
    logic       lat_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat     <= '0;
            lat_div <= 1'b0;
        end else if (start && !busy) begin
            lat     <= '0;
            lat_div <= op_div;
        end else if (busy) begin
            lat <= lat + 8'd1;
        end
    end

    AST_ZERO_CANON: assert property (@(posedge clk) disable iff (rst)
        done && (r_man == '0) |-> (r_exp == '0) && !r_sign); // R1
    AST_RESULT_NORM: assert property (@(posedge clk) disable iff (rst)
        done && (r_man != '0) |-> r_man[MAN_W-1]); // R2
    AST_OVF_SAT: assert property (@(posedge clk) disable iff (rst)
        done && ovf |-> (&r_man) && (r_exp == EXP_TOP)); // R6
    AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
        done && unf |-> (r_man == '0)); // R7
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot0({ovf, unf, dvz})); // R8
    AST_DVZ_SAT: assert property (@(posedge clk) disable iff (rst)
        done && dvz |-> (&r_man) && (r_exp == EXP_TOP)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat == (lat_div ? 8'(DIV_LAT) : 8'(MUL_LAT)))); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({r_sign, r_exp, r_man, ovf, unf, dvz})); // R12

endmodule

bind fpmd_unit fpmd_unit_chk #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_div (op_div),
    .busy   (busy),
    .done   (done),
    .r_sign (r_sign),
    .r_exp  (r_exp),
    .r_man  (r_man),
    .ovf    (ovf),
    .unf    (unf),
    .dvz    (dvz)
);

// File: tb/fpmd_unit_bench.sv
`timescale 1ns/1ps
module fpmd_unit_bench;

    // Vector: {op_div, a_sign, a_exp, a_man, b_sign, b_exp, b_man}
    typedef logic [50:0] vec_t;
    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 16'hC000, 1'b0, 8'h00, 16'hC000},
        {1'b0, 1'b0, 8'h00, 16'h8000, 1'b0, 8'h00, 16'h8000},
        {1'b0, 1'b1, 8'h05, 16'hA000, 1'b0, 8'hFD, 16'hE000},
        {1'b0, 1'b0, 8'h64, 16'hFFFF, 1'b1, 8'h1B, 16'hFFFF},
        {1'b0, 1'b0, 8'h9C, 16'h8000, 1'b0, 8'hE4, 16'h8000},
        {1'b0, 1'b1, 8'h9C, 16'h8000, 1'b0, 8'hE3, 16'h8000},
        {1'b0, 1'b1, 8'h10, 16'h0000, 1'b0, 8'h02, 16'h9000},
        {1'b0, 1'b0, 8'h7F, 16'h8000, 1'b0, 8'h00, 16'h8000},
        {1'b1, 1'b0, 8'h03, 16'hC000, 1'b0, 8'h01, 16'h8000},
        {1'b1, 1'b1, 8'h00, 16'h8000, 1'b0, 8'h00, 16'hC000},
        {1'b1, 1'b0, 8'h04, 16'h9ABC, 1'b1, 8'hFE, 16'hF123},
        {1'b1, 1'b1, 8'h05, 16'hC000, 1'b0, 8'h02, 16'h0000},
        {1'b1, 1'b0, 8'h05, 16'h0000, 1'b1, 8'h02, 16'h0000},
        {1'b1, 1'b0, 8'h05, 16'h0000, 1'b1, 8'h02, 16'h8000},
        {1'b1, 1'b0, 8'h7F, 16'h8000, 1'b0, 8'hFF, 16'h8000},
        {1'b1, 1'b0, 8'h80, 16'h8000, 1'b0, 8'h00, 16'hC000},
        {1'b0, 1'b0, 8'h01, 16'h8001, 1'b1, 8'h02, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst, start, op_div, a_sign, b_sign;
    logic [7:0]  a_exp, b_exp;
    logic [15:0] a_man, b_man;
    logic        busy, done, r_sign, ovf, unf, dvz;
    logic [7:0]  r_exp;
    logic [15:0] r_man;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fpmd_unit u_fpmd_unit (
        .clk(clk), .rst(rst), .start(start), .op_div(op_div),
        .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
        .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
        .busy(busy), .done(done), .r_sign(r_sign), .r_exp(r_exp),
        .r_man(r_man), .ovf(ovf), .unf(unf), .dvz(dvz)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected {sign, exp[7:0], man[15:0], ovf, unf, dvz}
    function automatic logic [27:0] model(input vec_t v);
        logic        dv, sa, sb, s;
        logic [7:0]  ea, eb;
        logic [15:0] am, bm, man;
        logic [31:0] p, q;
        int          xa, xb, e;
        {dv, sa, ea, am, sb, eb, bm} = v;
        s  = sa ^ sb;
        xa = $signed(ea);
        xb = $signed(eb);
        if (dv && !bm[15]) return {s, 8'h7F, 16'hFFFF, 3'b001};
        if (!am[15] || (!dv && !bm[15])) return '0;
        if (!dv) begin
            p = {16'h0, am} * {16'h0, bm};
            if (p[31]) begin man = p[31:16]; e = xa + xb + 1; end
            else       begin man = p[30:15]; e = xa + xb;     end
        end else begin
            q = {am, 16'h0} / {16'h0, bm};
            if (q[16]) begin man = q[16:1]; e = xa - xb;     end
            else       begin man = q[15:0]; e = xa - xb - 1; end
        end
        if (e > 127)  return {s, 8'h7F, 16'hFFFF, 3'b100};
        if (e < -128) return {1'b0, 8'h00, 16'h0000, 3'b010};
        return {s, e[7:0], man, 3'b000};
    endfunction

    function automatic string vtag(input vec_t v, input logic [27:0] e);
        if (e[0]) return "R8";
        if (e[1]) return "R7";
        if (e[2]) return "R6";
        if (e[18:3] == 16'h0) return v[50] ? "R9" : "R4";
        return v[50] ? "R5" : "R2";
    endfunction

    task automatic drive(input vec_t v);
        {op_div, a_sign, a_exp, a_man, b_sign, b_exp, b_man} = v;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (done !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_result(input vec_t v);
        logic [27:0] e;
        string       t;
        e = model(v);
        t = vtag(v, e);
        chk(r_man === e[18:3], t, "mantissa", 32'(r_man), 32'(e[18:3]));
        chk(r_exp === e[26:19], t, "exponent", 32'(r_exp), 32'(e[26:19]));
        chk({ovf, unf, dvz} === e[2:0], t, "flags ovf/unf/dvz", 32'({ovf, unf, dvz}), 32'(e[2:0]));
        if (e[18:3] != 16'h0)
            chk(r_sign === e[27], "R3", "sign", 32'(r_sign), 32'(e[27]));
        else
            chk({r_sign, r_exp} === 9'h0, "R1", "zero sign/exp", 32'({r_sign, r_exp}), 32'h0);
    endtask

    task automatic run_vec(input vec_t v);
        int          n;
        logic [27:0] snap;
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10", "busy after accept", 32'(busy), 32'h1);
        wait_done(n);
        chk(n == (v[50] ? 18 : 2), "R10", "latency", 32'(n), v[50] ? 32'd18 : 32'd2);
        check_result(v);
        snap = {r_sign, r_exp, r_man, ovf, unf, dvz};
        @(negedge clk);
        chk(done === 1'b0, "R10", "done width", 32'(done), 32'h0);
        chk({r_sign, r_exp, r_man, ovf, unf, dvz} === snap, "R12", "hold",
            32'({r_sign, r_exp, r_man, ovf, unf, dvz}), 32'(snap));
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        rst   = 1'b1;
        start = 1'b0;
        drive('0);
        repeat (3) @(negedge clk);
        chk({busy, done} === 2'b00, "R12", "reset busy/done", 32'({busy, done}), 32'h0);
        chk({r_sign, r_exp, r_man, ovf, unf, dvz} === 28'h0, "R12", "reset result",
            32'({r_sign, r_exp, r_man, ovf, unf, dvz}), 32'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R11: second start during a divide must not disturb it
        drive(VEC[8]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        drive(VEC[3]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drive(VEC[3]);
        wait_done(n);
        chk(n + 4 == 18, "R11", "latency with ignored start", 32'(n + 4), 32'd18);
        chk({r_sign, r_exp, r_man, ovf, unf, dvz} === model(VEC[8]), "R11", "result with ignored start",
            32'({r_sign, r_exp, r_man, ovf, unf, dvz}), 32'(model(VEC[8])));
        @(negedge clk);
        chk(busy === 1'b0, "R11", "idle after ignored start", 32'(busy), 32'h0);

        // Back-to-back: multiply right after the divide
        run_vec(VEC[1]);
        run_vec(VEC[10]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule